// File: doc/BRIEF.md
# Fetch-Packet Next-Line Predictor

This block guesses, in the same cycle that a fetch address is presented, where the front end should fetch next. It has three parts. A small fully-associative target buffer is keyed by the address of the head of a fetch packet. Each buffer entry carries a two-bit bimodal counter. A return address stack serves return entries. Each entry describes one control-flow instruction inside its packet: its kind, its slot within the packet and its target.

The lookup is purely combinational from the fetch address and the stored state. The block reports four things: whether an entry hit, whether the prediction is taken, the next fetch address, and the slot of the redirecting instruction, with a mask of the slots that stay valid. State changes only on a clock edge. Redirect events train and allocate buffer entries. Call and return events, decoded elsewhere, push and pop the stack. An event therefore affects predictions from the following cycle on.

Top module: `nlp_predictor`

## Requirements
- R1: After reset no entry is valid and the stack reads zero. Every lookup misses, with `pred_valid`=0 and `pred_taken`=0.
- R2: On a miss, or on a hit that is not taken, `pred_next_pc` is the fetch address rounded down to the packet boundary plus the packet size (16 bytes by default). In that case `pred_mask` is all ones and `pred_bidx` is FETCH_W-1.
- R3: A hit needs the full fetch address to equal the stored key of exactly one valid entry. Another address in the same packet misses.
- R4: The kind field is encoded as 0 for a conditional branch, 1 for a jump and 2 for a return. A hit on a jump entry is always taken and predicts the stored target. An update with kind 3 changes nothing.
- R5: A hit on a branch entry is taken exactly when its counter is 2 or 3. A newly allocated branch starts at 2. A branch update on a branch entry counts up when taken and down when not taken, saturating at 3 and 0.
- R6: A hit on a return entry is taken, and its next fetch address is the top of the return stack.
- R7: When taken, `pred_bidx` is the entry's slot and `pred_mask` has bits 0 through that slot set and all higher bits clear.
- R8: An entry is allocated only by a taken update whose address matches no entry. Allocation uses round-robin order over all entries, oldest first. A not-taken update that matches nothing has no effect.
- R9: A taken update whose address matches an entry rewrites that entry's kind, slot and target, and creates no new entry. If the entry turns into a branch from another kind, its counter becomes 2.
- R10: The stack has 8 slots. A push makes its address the top and wraps over the oldest slot when the stack is full. A pop exposes the previous top. A pop on an empty stack changes nothing. A push and a pop in the same cycle replace the top.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | PC_W | Address of the packet being fetched |
| pred_valid | output | 1 | An entry matched the fetch address |
| pred_taken | output | 1 | The prediction redirects fetch |
| pred_next_pc | output | PC_W | Predicted next fetch address |
| pred_bidx | output | BIDX_W | Slot of the redirecting instruction |
| pred_mask | output | FETCH_W | Slots that remain valid |
| upd_valid | input | 1 | Redirect event present |
| upd_fetch_pc | input | PC_W | Packet address of the event |
| upd_bidx | input | BIDX_W | Slot of the resolved instruction |
| upd_target | input | PC_W | Resolved target |
| upd_kind | input | 2 | 0 branch, 1 jump, 2 return, 3 none |
| upd_taken | input | 1 | Resolved direction |
| ras_push | input | 1 | Call decoded: push return address |
| ras_push_addr | input | PC_W | Return address to push |
| ras_pop | input | 1 | Return decoded: pop stack |

## Verification
Directed sequences train one branch entry through every counter value. These show whether the saturation limits and the weakly-taken start are right, and whether prediction depends on the counter's upper bit. Jump, return and ignored-kind updates separate the three prediction paths. Addresses inside an already-known packet tell exact-key matching apart from packet-granular matching. Filling the buffer past its capacity shows whether eviction follows allocation order. Deep pushes, pops past empty and combined push-pop cycles, observed through a return entry, separate wraparound from saturation. A pseudo-random mix of all event types, compared against a behavioural model each cycle, catches interactions that the directed cases miss.

// File: rtl/nlp_pkg.sv
package nlp_pkg;
  typedef enum logic [1:0] {
    K_BRANCH = 2'd0,
    K_JUMP   = 2'd1,
    K_RET    = 2'd2,
    K_NONE   = 2'd3
  } kind_e;

  localparam logic [1:0] CTR_WEAK_TAKEN = 2'd2;
endpackage

// File: rtl/nlp_tag_array.sv
module nlp_tag_array
  import nlp_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 8,
  parameter int BIDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PC_W-1:0]   lk_pc,
  output logic              hit,
  output logic [1:0]        hit_kind,
  output logic [BIDX_W-1:0] hit_bidx,
  output logic [PC_W-1:0]   hit_target,
  output logic              hit_ctr_hi,
  input  logic              upd_valid,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic [BIDX_W-1:0] upd_bidx,
  input  logic [PC_W-1:0]   upd_target,
  input  logic [1:0]        upd_kind,
  input  logic              upd_taken
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] ent_valid;
  logic [PC_W-1:0]    ent_key    [ENTRIES];
  logic [1:0]         ent_kind   [ENTRIES];
  logic [BIDX_W-1:0]  ent_bidx   [ENTRIES];
  logic [PC_W-1:0]    ent_target [ENTRIES];
  logic [1:0]         ent_ctr    [ENTRIES];
  logic [PTR_W-1:0]   rr_ptr;

  logic [ENTRIES-1:0] lk_match;
  logic [ENTRIES-1:0] up_match;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign lk_match[g] = ent_valid[g] && (ent_key[g] == lk_pc);
      assign up_match[g] = ent_valid[g] && (ent_key[g] == upd_pc);
    end
  endgenerate

  // unique match: at least one bit and no second bit
  assign hit = (lk_match != '0) && ((lk_match & (lk_match - 1'b1)) == '0);

  always_comb begin
    hit_kind   = '0;
    hit_bidx   = '0;
    hit_target = '0;
    hit_ctr_hi = 1'b0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (lk_match[e]) begin
        hit_kind   = hit_kind   | ent_kind[e];
        hit_bidx   = hit_bidx   | ent_bidx[e];
        hit_target = hit_target | ent_target[e];
        hit_ctr_hi = hit_ctr_hi | ent_ctr[e][1];
      end
    end
  end

  logic             up_any;
  logic [PTR_W-1:0] up_idx;

  always_comb begin
    up_any = 1'b0;
    up_idx = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (up_match[e]) begin
        up_any = 1'b1;
        up_idx = PTR_W'(e);
      end
    end
  end

  logic [1:0] cur_ctr;
  logic       cur_is_br;
  logic       upd_is_br;
  logic       upd_live;

  assign cur_ctr   = ent_ctr[up_idx];
  assign cur_is_br = (ent_kind[up_idx] == K_BRANCH);
  assign upd_is_br = (upd_kind == K_BRANCH);
  assign upd_live  = upd_valid && (upd_kind != K_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_valid <= '0;
      rr_ptr    <= '0;
    end else if (upd_live) begin
      if (up_any) begin
        if (upd_taken) begin
          ent_kind[up_idx]   <= upd_kind;
          ent_bidx[up_idx]   <= upd_bidx;
          ent_target[up_idx] <= upd_target;
          if (upd_is_br)
            ent_ctr[up_idx] <= !cur_is_br ? CTR_WEAK_TAKEN :
                               (cur_ctr == 2'd3) ? cur_ctr : cur_ctr + 2'd1;
        end else if (upd_is_br && cur_is_br) begin
          ent_ctr[up_idx] <= (cur_ctr == 2'd0) ? cur_ctr : cur_ctr - 2'd1;
        end
      end else if (upd_taken) begin
        ent_valid[rr_ptr]  <= 1'b1;
        ent_key[rr_ptr]    <= upd_pc;
        ent_kind[rr_ptr]   <= upd_kind;
        ent_bidx[rr_ptr]   <= upd_bidx;
        ent_target[rr_ptr] <= upd_target;
        ent_ctr[rr_ptr]    <= CTR_WEAK_TAKEN;
        rr_ptr <= (rr_ptr == PTR_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/nlp_ras.sv
module nlp_ras #(
  parameter int PC_W  = 32,
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic [PC_W-1:0] push_addr,
  input  logic            pop,
  output logic [PC_W-1:0] top,
  output logic            empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [PC_W-1:0]  stk [DEPTH];
  logic [PTR_W-1:0] tp;
  logic [CNT_W-1:0] cnt;
  logic [PTR_W-1:0] tp_up;
  logic [PTR_W-1:0] tp_dn;

  assign tp_up = (tp == PTR_W'(DEPTH - 1)) ? '0 : tp + 1'b1;
  assign tp_dn = (tp == '0) ? PTR_W'(DEPTH - 1) : tp - 1'b1;
  assign top   = stk[tp];
  assign empty = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      tp  <= '0;
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
    end else if (push && pop) begin
      stk[tp] <= push_addr;
    end else if (push) begin
      stk[tp_up] <= push_addr;
      tp         <= tp_up;
      if (cnt != CNT_W'(DEPTH)) cnt <= cnt + 1'b1;
    end else if (pop && !empty) begin
      tp  <= tp_dn;
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/nlp_select.sv
module nlp_select
  import nlp_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int FETCH_W = 4,
  parameter int BIDX_W  = 2,
  parameter int OFS_W   = 4
) (
  input  logic [PC_W-1:0]    pc,
  input  logic               hit,
  input  logic [1:0]         kind,
  input  logic [BIDX_W-1:0]  bidx,
  input  logic [PC_W-1:0]    target,
  input  logic               ctr_hi,
  input  logic [PC_W-1:0]    ras_top,
  output logic               valid,
  output logic               taken,
  output logic [PC_W-1:0]    next_pc,
  output logic [BIDX_W-1:0]  bidx_o,
  output logic [FETCH_W-1:0] mask
);
  localparam logic [PC_W-1:0] PKT_SIZE = PC_W'(1) << OFS_W;

  logic [PC_W-1:0] seq_pc;

  assign seq_pc = (pc & ~(PKT_SIZE - 1'b1)) + PKT_SIZE;
  assign valid  = hit;

  always_comb begin
    taken = 1'b0;
    if (hit) begin
      unique case (kind)
        K_BRANCH: taken = ctr_hi;
        K_JUMP:   taken = 1'b1;
        K_RET:    taken = 1'b1;
        default:  taken = 1'b0;
      endcase
    end
  end

  always_comb begin
    next_pc = seq_pc;
    bidx_o  = BIDX_W'(FETCH_W - 1);
    if (taken) begin
      next_pc = (kind == K_RET) ? ras_top : target;
      bidx_o  = bidx;
    end
  end

  genvar s;
  generate
    for (s = 0; s < FETCH_W; s++) begin : g_mask
      assign mask[s] = !taken || (BIDX_W'(s) <= bidx);
    end
  endgenerate
endmodule

// File: rtl/nlp_predictor.sv
module nlp_predictor
  import nlp_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int FETCH_W    = 4,
  parameter int INSN_BYTES = 4,
  parameter int ENTRIES    = 8,
  parameter int RAS_DEPTH  = 8,
  localparam int BIDX_W    = (FETCH_W > 1) ? $clog2(FETCH_W) : 1,
  localparam int OFS_W     = $clog2(FETCH_W * INSN_BYTES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PC_W-1:0]    fetch_pc,
  output logic               pred_valid,
  output logic               pred_taken,
  output logic [PC_W-1:0]    pred_next_pc,
  output logic [BIDX_W-1:0]  pred_bidx,
  output logic [FETCH_W-1:0] pred_mask,
  input  logic               upd_valid,
  input  logic [PC_W-1:0]    upd_fetch_pc,
  input  logic [BIDX_W-1:0]  upd_bidx,
  input  logic [PC_W-1:0]    upd_target,
  input  logic [1:0]         upd_kind,
  input  logic               upd_taken,
  input  logic               ras_push,
  input  logic [PC_W-1:0]    ras_push_addr,
  input  logic               ras_pop
);
  logic              hit;
  logic [1:0]        hit_kind;
  logic [BIDX_W-1:0] hit_bidx;
  logic [PC_W-1:0]   hit_target;
  logic              hit_ctr_hi;
  logic [PC_W-1:0]   ras_top;
  logic              ras_empty;

  nlp_tag_array #(.PC_W(PC_W), .ENTRIES(ENTRIES), .BIDX_W(BIDX_W)) u_tags (
    .clk(clk), .rst(rst), .lk_pc(fetch_pc),
    .hit(hit), .hit_kind(hit_kind), .hit_bidx(hit_bidx),
    .hit_target(hit_target), .hit_ctr_hi(hit_ctr_hi),
    .upd_valid(upd_valid), .upd_pc(upd_fetch_pc), .upd_bidx(upd_bidx),
    .upd_target(upd_target), .upd_kind(upd_kind), .upd_taken(upd_taken)
  );

  nlp_ras #(.PC_W(PC_W), .DEPTH(RAS_DEPTH)) u_ras (
    .clk(clk), .rst(rst), .push(ras_push), .push_addr(ras_push_addr),
    .pop(ras_pop), .top(ras_top), .empty(ras_empty)
  );

  nlp_select #(.PC_W(PC_W), .FETCH_W(FETCH_W), .BIDX_W(BIDX_W), .OFS_W(OFS_W)) u_sel (
    .pc(fetch_pc), .hit(hit), .kind(hit_kind), .bidx(hit_bidx),
    .target(hit_target), .ctr_hi(hit_ctr_hi), .ras_top(ras_top),
    .valid(pred_valid), .taken(pred_taken), .next_pc(pred_next_pc),
    .bidx_o(pred_bidx), .mask(pred_mask)
  );
endmodule

// File: rtl/nlp_checker.sv
module nlp_checker
  import nlp_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int FETCH_W = 4,
  parameter int BIDX_W  = 2,
  parameter int OFS_W   = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               pred_valid,
  input logic               pred_taken,
  input logic [PC_W-1:0]    pred_next_pc,
  input logic [BIDX_W-1:0]  pred_bidx,
  input logic [FETCH_W-1:0] pred_mask,
  input logic [1:0]         hit_kind,
  input logic [PC_W-1:0]    ras_top,
  input logic               ras_empty,
  input logic               ras_push,
  input logic [PC_W-1:0]    ras_push_addr,
  input logic               ras_pop
);
  assert_taken_needs_hit_R2: assert property (@(posedge clk) disable iff (rst)
    pred_taken |-> pred_valid);

  assert_seq_aligned_R2: assert property (@(posedge clk) disable iff (rst)
    !pred_taken |-> (pred_next_pc[OFS_W-1:0] == '0));

  assert_mask_shape_R7: assert property (@(posedge clk) disable iff (rst)
    pred_taken |-> (pred_mask[0] && ($countones(pred_mask) == int'(pred_bidx) + 1)));

  assert_return_from_stack_R6: assert property (@(posedge clk) disable iff (rst)
    (pred_valid && hit_kind == K_RET) |-> (pred_taken && pred_next_pc == ras_top));

  assert_push_sets_top_R10: assert property (@(posedge clk) disable iff (rst)
    (ras_push && !ras_pop) |=> (ras_top == $past(ras_push_addr) && !ras_empty));

  assert_empty_pop_inert_R10: assert property (@(posedge clk) disable iff (rst)
    (ras_empty && ras_pop && !ras_push) |=> ($stable(ras_top) && ras_empty));
endmodule

bind nlp_predictor nlp_checker #(
  .PC_W(PC_W), .FETCH_W(FETCH_W), .BIDX_W(BIDX_W), .OFS_W(OFS_W)
) u_chk (
  .clk(clk), .rst(rst), .pred_valid(pred_valid), .pred_taken(pred_taken),
  .pred_next_pc(pred_next_pc), .pred_bidx(pred_bidx), .pred_mask(pred_mask),
  .hit_kind(hit_kind), .ras_top(ras_top), .ras_empty(ras_empty),
  .ras_push(ras_push), .ras_push_addr(ras_push_addr), .ras_pop(ras_pop)
);

// File: tb/nlp_predictor_test.sv
module nlp_predictor_test;
  localparam int NE = 8;
  localparam int ND = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] fetch_pc = '0;
  logic        pred_valid, pred_taken;
  logic [31:0] pred_next_pc;
  logic [1:0]  pred_bidx;
  logic [3:0]  pred_mask;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_fetch_pc = '0;
  logic [1:0]  upd_bidx = '0;
  logic [31:0] upd_target = '0;
  logic [1:0]  upd_kind = '0;
  logic        upd_taken = 1'b0;
  logic        ras_push = 1'b0;
  logic [31:0] ras_push_addr = '0;
  logic        ras_pop = 1'b0;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  nlp_predictor uut (
    .clk(clk), .rst(rst), .fetch_pc(fetch_pc),
    .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_next_pc(pred_next_pc),
    .pred_bidx(pred_bidx), .pred_mask(pred_mask),
    .upd_valid(upd_valid), .upd_fetch_pc(upd_fetch_pc), .upd_bidx(upd_bidx),
    .upd_target(upd_target), .upd_kind(upd_kind), .upd_taken(upd_taken),
    .ras_push(ras_push), .ras_push_addr(ras_push_addr), .ras_pop(ras_pop)
  );

  // behavioural reference state
  bit          m_v   [NE];
  logic [31:0] m_key [NE];
  int          m_kind[NE];
  int          m_bi  [NE];
  logic [31:0] m_tgt [NE];
  int          m_ctr [NE];
  int          m_rr = 0;
  logic [31:0] m_stk [ND];
  int          m_tp = 0;
  int          m_cnt = 0;

  initial begin
    for (int i = 0; i < NE; i++) m_v[i] = 0;
    for (int i = 0; i < ND; i++) m_stk[i] = '0;
  end

  function automatic int find(input logic [31:0] pc);
    int h = -1;
    for (int e = 0; e < NE; e++) if (m_v[e] && m_key[e] == pc) h = e;
    return h;
  endfunction

  task automatic cyc(input string tag);
    int h; bit ev, et; logic [31:0] enp; int ebi; logic [3:0] emk;
    #5;
    h = find(fetch_pc);
    ev = (h >= 0); et = 0;
    enp = (fetch_pc & ~32'hF) + 32'd16; ebi = 3; emk = 4'hF;
    if (ev) et = (m_kind[h] == 0) ? (m_ctr[h] >= 2) : (m_kind[h] <= 2);
    if (et) begin
      ebi = m_bi[h];
      enp = (m_kind[h] == 2) ? m_stk[m_tp] : m_tgt[h];
      emk = 4'((1 << (ebi + 1)) - 1);
    end
    checks++;
    if (pred_valid !== ev || pred_taken !== et || pred_next_pc !== enp ||
        int'(pred_bidx) != ebi || pred_mask !== emk) begin
      errors++;
      $display("FAIL %s pc=%h: got v=%b t=%b np=%h bi=%0d m=%b, want v=%b t=%b np=%h bi=%0d m=%b",
               tag, fetch_pc, pred_valid, pred_taken, pred_next_pc, pred_bidx, pred_mask,
               ev, et, enp, ebi, emk);
    end
    @(posedge clk);
    // reference update with the inputs sampled at this edge
    if (ras_push && ras_pop) m_stk[m_tp] = ras_push_addr;
    else if (ras_push) begin
      m_tp = (m_tp + 1) % ND; m_stk[m_tp] = ras_push_addr;
      if (m_cnt < ND) m_cnt++;
    end else if (ras_pop && m_cnt > 0) begin
      m_tp = (m_tp + ND - 1) % ND; m_cnt--;
    end
    if (upd_valid && upd_kind != 2'd3) begin
      h = find(upd_fetch_pc);
      if (h >= 0) begin
        if (upd_taken) begin
          if (upd_kind == 2'd0) m_ctr[h] = (m_kind[h] != 0) ? 2 : (m_ctr[h] < 3 ? m_ctr[h] + 1 : 3);
          m_kind[h] = int'(upd_kind); m_bi[h] = int'(upd_bidx); m_tgt[h] = upd_target;
        end else if (upd_kind == 2'd0 && m_kind[h] == 0) begin
          if (m_ctr[h] > 0) m_ctr[h]--;
        end
      end else if (upd_taken) begin
        m_v[m_rr] = 1; m_key[m_rr] = upd_fetch_pc; m_kind[m_rr] = int'(upd_kind);
        m_bi[m_rr] = int'(upd_bidx); m_tgt[m_rr] = upd_target; m_ctr[m_rr] = 2;
        m_rr = (m_rr + 1) % NE;
      end
    end
    @(negedge clk);
    upd_valid = 0; ras_push = 0; ras_pop = 0;
  endtask

  task automatic look(input logic [31:0] pc, input string tag);
    fetch_pc = pc; cyc(tag);
  endtask

  task automatic upd(input logic [31:0] pc, input int bi, input logic [31:0] tg,
                     input int k, input bit tk, input string tag);
    upd_valid = 1; upd_fetch_pc = pc; upd_bidx = 2'(bi); upd_target = tg;
    upd_kind = 2'(k); upd_taken = tk; fetch_pc = pc; cyc(tag);
  endtask

  task automatic push(input logic [31:0] a, input string tag);
    ras_push = 1; ras_push_addr = a; fetch_pc = 32'h300; cyc(tag);
  endtask

  task automatic pop(input string tag);
    ras_pop = 1; fetch_pc = 32'h300; cyc(tag);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hung run, want completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    rst = 0;
    look(32'h0, "R1");
    look(32'h100, "R1");
    look(32'h300, "R1");
    // first branch: allocation at weakly taken
    upd(32'h100, 2, 32'h400, 0, 1, "R8");
    look(32'h100, "R5");
    look(32'h104, "R3");
    look(32'h10C, "R3");
    look(32'h1F4, "R2");
    // counter walk
    upd(32'h100, 2, 32'h400, 0, 0, "R5");
    upd(32'h100, 2, 32'h400, 0, 0, "R5");
    look(32'h100, "R2");
    upd(32'h100, 2, 32'h400, 0, 0, "R5");
    look(32'h100, "R5");
    upd(32'h100, 2, 32'h400, 0, 1, "R5");
    look(32'h100, "R5");
    for (int i = 0; i < 4; i++) upd(32'h100, 2, 32'h400, 0, 1, "R5");
    upd(32'h100, 2, 32'h400, 0, 0, "R5");
    look(32'h100, "R5");
    // jump entry, slot 0 mask
    upd(32'h200, 0, 32'h800, 1, 1, "R4");
    look(32'h200, "R4");
    look(32'h200, "R7");
    // return entry through the stack
    push(32'h1234, "R10");
    push(32'h5678, "R10");
    upd(32'h300, 3, 32'hDEAD0, 2, 1, "R6");
    look(32'h300, "R6");
    pop("R6");
    look(32'h300, "R6");
    // no allocation paths
    upd(32'h500, 1, 32'h900, 0, 0, "R8");
    look(32'h500, "R8");
    upd(32'h600, 1, 32'h900, 3, 1, "R4");
    look(32'h600, "R4");
    // rewrite of a matching entry
    upd(32'h200, 1, 32'hA00, 0, 1, "R9");
    look(32'h200, "R9");
    look(32'h208, "R9");
    // fill past capacity: round-robin eviction
    for (int i = 0; i < 6; i++) upd(32'h1000 + 32'(16 * i), i % 4, 32'h2000 + 32'(i), 1, 1, "R8");
    look(32'h100, "R8");
    look(32'h1050, "R8");
    look(32'h200, "R8");
    // stack: empty pops, wrap, combined push/pop
    pop("R10"); pop("R10"); pop("R10");
    look(32'h300, "R10");
    for (int i = 0; i < 9; i++) push(32'h40 + 32'(4 * i), "R10");
    for (int i = 0; i < 9; i++) pop("R10");
    ras_push = 1; ras_pop = 1; ras_push_addr = 32'hBEEF0; fetch_pc = 32'h300; cyc("R10");
    look(32'h300, "R10");
    // mixed pseudo-random traffic
    lf = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      fetch_pc = 32'h3000 + 32'({lf[3:0], 4'h0}) + 32'({lf[5:4], 2'b00} & 32'h4);
      if (lf[6]) begin
        upd_valid = 1; upd_fetch_pc = 32'h3000 + 32'({lf[10:7], 4'h0});
        upd_bidx = lf[12:11]; upd_target = 32'h9000 + 32'(lf); upd_kind = lf[14:13];
        upd_taken = lf[15] | lf[1];
      end
      ras_push = lf[8] & lf[2]; ras_push_addr = 32'h7000 + 32'(i * 4);
      ras_pop = lf[9] & lf[0];
      cyc("R9");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule